// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block sits between the two wire pins of a serial memory device and the controller that owns the storage. It oversamples the clock and data lines with a fast system clock, removes short glitches, and finds the bus framing conditions. A falling data line while the clock is high opens a transfer. A rising data line while the clock is high closes it. After an opening condition it shifts in a select byte and compares it against two accepted type codes and a three-bit strap value. It acknowledges by pulling the data line low, and it then moves whole bytes towards or away from the controller.

The controller sees single-cycle strobes. One strobe reports a select that was accepted, along with its direction and which space it addressed. Another marks each byte received. A third marks each byte taken for transmission, and a fourth reports a closing condition. While the controller signals that an internal write cycle is in progress, every select goes unanswered, so a master can poll for completion. A new opening condition at any point throws away the transfer in progress.

Top module: `tws_slave`

## Requirements
- R1: A low or high pulse on either pin that lasts fewer than FILT_LEN consecutive synchronized samples (default 3) is discarded. It produces no framing event and no strobe.
- R2: A rising data line while the clock is high is a closing condition. It pulses `stop_o` for one cycle, releases the data line and returns the block to idle.
- R3: A select byte whose bits 7:4 are 1010 and whose bits 3:1 equal `strap_i` is accepted. The block pulls the data line low for the whole ninth clock, pulses `sel_stb_o`, sets `sel_read_o` to bit 0 (1 = read) and clears `sel_id_o`.
- R4: A select byte whose bits 7:4 are 1011 and whose bits 3:1 equal `strap_i` is accepted in the same way, with `sel_id_o` set to 1.
- R5: When the type code or the strap bits of a select byte do not match, the block leaves the data line released in the ninth clock and issues no strobe. It then ignores every later byte until the next opening condition.
- R6: While `busy_i` is 1, a matching select byte gets no acknowledge and no `sel_stb_o`. Once `busy_i` is 0 again, the same select is acknowledged.
- R7: In a write transfer, each following byte is sampled MSB first on rising clock edges. It appears on `wr_data_o` with a one-cycle `wr_stb_o` pulse and is acknowledged in its ninth clock.
- R8: In a read transfer, the block loads `rd_data_i` and pulses `rd_take_o` once per byte, then drives the byte MSB first, changing the line only while the clock is low. A master acknowledge (low) in the ninth clock starts the next byte. A master no-acknowledge (high) ends transmission with the line released.
- R9: An opening condition that arrives in the middle of a byte abandons that byte and starts a new select phase.
- R10: Out of reset and after a closing condition, clocked bits that are not preceded by an opening condition produce no acknowledge and no strobe.
- R11: While and after reset, the data line is released, no strobe is active, and `sel_read_o` and `sel_id_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls the data pin low (open drain) |
| strap_i | input | 3 | Board strap value compared with select bits 3:1 |
| busy_i | input | 1 | Internal write cycle in progress; selects are refused |
| sel_stb_o | output | 1 | One-cycle pulse on an accepted select |
| sel_read_o | output | 1 | Direction of the last accepted select (1 = read) |
| sel_id_o | output | 1 | Last accepted select addressed the identification space |
| wr_stb_o | output | 1 | One-cycle pulse: a write data byte was received |
| wr_data_o | output | 8 | Last received write byte |
| rd_data_i | input | 8 | Byte to transmit; must be valid until `rd_take_o` pulses |
| rd_take_o | output | 1 | One-cycle pulse after a read byte was loaded |
| stop_o | output | 1 | One-cycle pulse on a closing condition |

## Verification
A pin change reaches the filtered level SYNC_STAGES + FILT_LEN cycles later, which is 5 cycles by default. Strobes go high one cycle after that, and the data drive changes one cycle after a filtered clock fall. The bench holds each clock phase for 16 cycles, so every response settles well inside a phase. It reads the acknowledge and read data bits two cycles before the clock falls. It checks strobe counts, captured bytes and `sda_oe_o` only after the phase that caused them has ended, never on a clock edge.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int          BYTE_W    = 8;
    localparam int          BIT_CNT_W = $clog2(BYTE_W);
    localparam logic [3:0]  TYPE_MAIN = 4'b1010;
    localparam logic [3:0]  TYPE_ID   = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tws_state_e;

    typedef struct packed {
        tws_state_e             st;
        logic [BYTE_W-1:0]      shreg;
        logic [BIT_CNT_W-1:0]   cnt;
        logic                   ack_on;
        logic                   oe;
        logic                   rd_dir;
        logic                   id_sp;
        logic                   sel_stb;
        logic                   wr_stb;
        logic                   rd_take;
        logic                   stop;
        logic [BYTE_W-1:0]      wr_data;
    } tws_regs_t;

endpackage

// File: rtl/tws_filter.sv
module tws_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 3,
    parameter logic RST_LVL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;
    logic [CW-1:0]          cnt_d, cnt_q;
    logic                   lvl_d, lvl_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= RST_LVL;
                else        sync_q <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= {SYNC_STAGES{RST_LVL}};
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign samp = sync_q[SYNC_STAGES-1];

    always_comb begin
        lvl_d = lvl_q;
        cnt_d = '0;
        if (samp != lvl_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) lvl_d = samp;
            else                            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= RST_LVL;
            cnt_q <= '0;
        end else begin
            lvl_q <= lvl_d;
            cnt_q <= cnt_d;
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/tws_cond.sv
module tws_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        start_o = scl_i & scl_q &  sda_q & ~sda_i;
        stop_o  = scl_i & scl_q & ~sda_q &  sda_i;
        rise_o  =  scl_i & ~scl_q;
        fall_o  = ~scl_i &  scl_q;
    end

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  strap_i,
    input  logic        busy_i,
    output logic        sel_stb_o,
    output logic        sel_read_o,
    output logic        sel_id_o,
    output logic        wr_stb_o,
    output logic [7:0]  wr_data_o,
    input  logic [7:0]  rd_data_i,
    output logic        rd_take_o,
    output logic        stop_o
);
    localparam int N_LINES = 2;
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic [N_LINES-1:0] line_raw, line_f;
    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    assign line_raw = {sda_i, scl_i};

    generate
        for (genvar k = 0; k < N_LINES; k++) begin : g_line
            tws_filter #(
                .SYNC_STAGES (SYNC_STAGES),
                .FILT_LEN    (FILT_LEN),
                .RST_LVL     (1'b1)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .raw_i (line_raw[k]),
                .lvl_o (line_f[k])
            );
        end
    endgenerate

    assign scl_f = line_f[0];
    assign sda_f = line_f[1];

    tws_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_f),
        .sda_i   (sda_f),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    tws_regs_t r_d, r_q;
    logic [BYTE_W-1:0] byte_in;
    logic              type_ok, strap_ok;

    always_comb begin
        r_d         = r_q;
        r_d.sel_stb = 1'b0;
        r_d.wr_stb  = 1'b0;
        r_d.rd_take = 1'b0;
        r_d.stop    = 1'b0;

        byte_in  = {r_q.shreg[BYTE_W-2:0], sda_f};
        type_ok  = (byte_in[7:4] == TYPE_MAIN) || (byte_in[7:4] == TYPE_ID);
        strap_ok = (byte_in[3:1] == strap_i);

        if (ev_start) begin
            r_d.st     = ST_SEL;
            r_d.cnt    = '0;
            r_d.oe     = 1'b0;
            r_d.ack_on = 1'b0;
        end else if (ev_stop) begin
            r_d.st     = ST_IDLE;
            r_d.oe     = 1'b0;
            r_d.ack_on = 1'b0;
            r_d.stop   = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.oe = 1'b0;
                end
                ST_SEL: begin
                    if (ev_rise) begin
                        r_d.shreg = byte_in;
                        r_d.cnt   = r_q.cnt + 1'b1;
                        if (r_q.cnt == LAST_BIT) begin
                            if (type_ok && strap_ok && !busy_i) begin
                                r_d.sel_stb = 1'b1;
                                r_d.rd_dir  = byte_in[0];
                                r_d.id_sp   = (byte_in[7:4] == TYPE_ID);
                                r_d.ack_on  = 1'b0;
                                r_d.st      = ST_SEL_ACK;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end
                    end
                end
                ST_SEL_ACK: begin
                    if (ev_fall) begin
                        if (!r_q.ack_on) begin
                            r_d.oe     = 1'b1;
                            r_d.ack_on = 1'b1;
                        end else begin
                            r_d.ack_on = 1'b0;
                            r_d.cnt    = '0;
                            if (r_q.rd_dir) begin
                                r_d.shreg   = rd_data_i;
                                r_d.oe      = ~rd_data_i[BYTE_W-1];
                                r_d.rd_take = 1'b1;
                                r_d.st      = ST_RD;
                            end else begin
                                r_d.oe = 1'b0;
                                r_d.st = ST_WR;
                            end
                        end
                    end
                end
                ST_WR: begin
                    if (ev_rise) begin
                        r_d.shreg = byte_in;
                        r_d.cnt   = r_q.cnt + 1'b1;
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.wr_stb  = 1'b1;
                            r_d.wr_data = byte_in;
                            r_d.ack_on  = 1'b0;
                            r_d.st      = ST_WR_ACK;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev_fall) begin
                        if (!r_q.ack_on) begin
                            r_d.oe     = 1'b1;
                            r_d.ack_on = 1'b1;
                        end else begin
                            r_d.oe     = 1'b0;
                            r_d.ack_on = 1'b0;
                            r_d.cnt    = '0;
                            r_d.st     = ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (ev_fall) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_RD_ACK;
                        end else begin
                            r_d.shreg = {r_q.shreg[BYTE_W-2:0], 1'b0};
                            r_d.oe    = ~r_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise && sda_f) begin
                        r_d.st = ST_IDLE;
                    end else if (ev_fall) begin
                        r_d.shreg   = rd_data_i;
                        r_d.oe      = ~rd_data_i[BYTE_W-1];
                        r_d.rd_take = 1'b1;
                        r_d.cnt     = '0;
                        r_d.st      = ST_RD;
                    end
                end
                default: begin
                    r_d.st = ST_IDLE;
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o   = r_q.oe;
    assign sel_stb_o  = r_q.sel_stb;
    assign sel_read_o = r_q.rd_dir;
    assign sel_id_o   = r_q.id_sp;
    assign wr_stb_o   = r_q.wr_stb;
    assign wr_data_o  = r_q.wr_data;
    assign rd_take_o  = r_q.rd_take;
    assign stop_o     = r_q.stop;

endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic busy_i,
    input logic sda_oe_o,
    input logic sel_stb_o,
    input logic sel_read_o,
    input logic wr_stb_o,
    input logic rd_take_o,
    input logic stop_o
);
    AST_DRIVE_ONLY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_f)); // R8

    AST_SEL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb_o |-> !$past(busy_i)); // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_stb_o, wr_stb_o, rd_take_o, stop_o})); // R7

    AST_TAKE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take_o |-> sel_read_o); // R8

    AST_WRITE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !sel_read_o); // R7

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !sda_oe_o); // R2

    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o); // R2

endmodule

bind tws_slave tws_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_f),
    .busy_i     (busy_i),
    .sda_oe_o   (sda_oe_o),
    .sel_stb_o  (sel_stb_o),
    .sel_read_o (sel_read_o),
    .wr_stb_o   (wr_stb_o),
    .rd_take_o  (rd_take_o),
    .stop_o     (stop_o)
);

// File: tb/tb_tws_slave.sv
`timescale 1ns/1ps
module tb_tws_slave;
    localparam int HALF = 16;
    localparam logic [2:0] STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       busy = 1'b0;
    logic       sda_bus;
    logic       sda_oe_o, sel_stb_o, sel_read_o, sel_id_o, wr_stb_o, rd_take_o, stop_o;
    logic [7:0] wr_data_o;
    logic [7:0] rd_data;

    int n_chk = 0, n_fail = 0;
    int n_sel = 0, n_wr = 0, n_take = 0, n_stop = 0;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe_o;

    tws_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe_o),
        .strap_i(STRAP), .busy_i(busy), .sel_stb_o(sel_stb_o), .sel_read_o(sel_read_o),
        .sel_id_o(sel_id_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
        .rd_data_i(rd_data), .rd_take_o(rd_take_o), .stop_o(stop_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h96;
        end else begin
            if (sel_stb_o) n_sel  <= n_sel + 1;
            if (wr_stb_o)  n_wr   <= n_wr + 1;
            if (rd_take_o) begin
                n_take  <= n_take + 1;
                rd_data <= rd_data + 8'h11;
            end
            if (stop_o)    n_stop <= n_stop + 1;
        end
    end

    // {select byte, data byte, expect ack, expect id space}
    localparam logic [17:0] VEC [0:6] = '{
        {8'hAA, 8'h3C, 1'b1, 1'b0},
        {8'hBA, 8'hC5, 1'b1, 1'b1},
        {8'hA8, 8'h11, 1'b0, 1'b0},
        {8'h2A, 8'h22, 1'b0, 1'b0},
        {8'hAA, 8'h00, 1'b1, 1'b0},
        {8'hBA, 8'hFF, 1'b1, 1'b1},
        {8'hAE, 8'h33, 1'b0, 1'b0}
    };

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wcyc(HALF);
        m_scl = 1'b1; wcyc(HALF);
        m_sda = 1'b0; wcyc(HALF);
        m_scl = 1'b0; wcyc(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wcyc(HALF);
        m_scl = 1'b1; wcyc(HALF);
        m_sda = 1'b1; wcyc(HALF);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b;    wcyc(HALF);
        m_scl = 1'b1; wcyc(HALF);
        m_scl = 1'b0; wcyc(4);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; wcyc(HALF);
        m_scl = 1'b1; wcyc(HALF - 2);
        b = sda_bus;  wcyc(2);
        m_scl = 1'b0; wcyc(4);
    endtask

    task automatic byte_out(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic byte_in(output logic [7:0] d, input logic m_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~m_ack);
    endtask

    initial begin
        logic ack;
        logic [7:0] rd0, rd1;
        int s0, w0, t0, p0;

        // R11 reset state
        wcyc(3);
        chk(sda_oe_o == 1'b0 && sel_stb_o == 1'b0, "R11", "oe/strobe in reset", sda_oe_o, 0);
        rst_n = 1'b1;
        wcyc(10);
        chk({sda_oe_o, sel_read_o, sel_id_o, wr_stb_o, rd_take_o, stop_o} == 6'b0,
            "R11", "outputs after reset", {sda_oe_o, sel_read_o, sel_id_o}, 0);

        // Table of select/data vectors: R3 R4 R5 R7
        for (int i = 0; i < 7; i++) begin
            logic [17:0] v;
            v  = VEC[i];
            s0 = n_sel; w0 = n_wr;
            bus_start();
            byte_out(v[17:10], ack);
            chk(ack == v[1], v[0] ? "R4" : (v[1] ? "R3" : "R5"), "select ack", ack, v[1]);
            chk(n_sel - s0 == int'(v[1]), "R3", "select strobe count", n_sel - s0, v[1]);
            if (v[1]) chk(sel_id_o == v[0] && sel_read_o == 1'b0, "R4", "id space flag", sel_id_o, v[0]);
            byte_out(v[9:2], ack);
            chk(ack == v[1], v[1] ? "R7" : "R5", "data ack", ack, v[1]);
            chk(n_wr - w0 == int'(v[1]), v[1] ? "R7" : "R5", "write strobe count", n_wr - w0, v[1]);
            if (v[1]) chk(wr_data_o == v[9:2], "R7", "write data", wr_data_o, v[9:2]);
            bus_stop();
            chk(sda_oe_o == 1'b0, "R2", "released after stop", sda_oe_o, 0);
        end

        // R1 short glitch on data while clock high and idle
        p0 = n_stop; s0 = n_sel;
        m_sda = 1'b0; wcyc(2); m_sda = 1'b1; wcyc(20);
        chk(n_stop == p0 && n_sel == s0, "R1", "glitch ignored", n_stop - p0, 0);
        // R2 a real low pulse forms open then close
        m_sda = 1'b0; wcyc(10); m_sda = 1'b1; wcyc(20);
        chk(n_stop - p0 == 1, "R2", "stop strobe count", n_stop - p0, 1);

        // R6 busy refuses select, then polling succeeds
        busy = 1'b1; s0 = n_sel;
        bus_start();
        byte_out(8'hAA, ack);
        chk(ack == 1'b0, "R6", "select ack while busy", ack, 0);
        chk(n_sel == s0, "R6", "no strobe while busy", n_sel - s0, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        byte_out(8'hAA, ack);
        chk(ack == 1'b1, "R6", "select ack after busy", ack, 1);
        bus_stop();

        // R8 sequential read: ack first byte, nack second
        t0 = n_take;
        bus_start();
        byte_out(8'hAB, ack);
        chk(ack == 1'b1 && sel_read_o == 1'b1, "R8", "read select", {ack, sel_read_o}, 3);
        byte_in(rd0, 1'b1);
        byte_in(rd1, 1'b0);
        chk(rd0 == 8'h96, "R8", "read byte 0", rd0, 8'h96);
        chk(rd1 == 8'hA7, "R8", "read byte 1", rd1, 8'hA7);
        chk(sda_oe_o == 1'b0, "R8", "released after nack", sda_oe_o, 0);
        bus_stop();
        chk(n_take - t0 == 2, "R8", "take strobe count", n_take - t0, 2);

        // R9 open condition mid-byte restarts select phase
        s0 = n_sel; w0 = n_wr;
        bus_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        bus_start();
        byte_out(8'hAA, ack);
        chk(ack == 1'b1, "R9", "select after restart", ack, 1);
        byte_out(8'h5A, ack);
        chk(n_wr - w0 == 1 && wr_data_o == 8'h5A, "R9", "data after restart", wr_data_o, 8'h5A);
        chk(n_sel - s0 == 1, "R9", "one select strobe", n_sel - s0, 1);
        bus_stop();

        // R10 bits without an open condition are ignored
        s0 = n_sel; w0 = n_wr;
        m_scl = 1'b0; wcyc(HALF);
        byte_out(8'hAA, ack);
        chk(ack == 1'b0, "R10", "no ack without open", ack, 0);
        byte_out(8'h77, ack);
        chk(n_sel == s0 && n_wr == w0, "R10", "no strobes without open", n_sel - s0, 0);
        bus_stop();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule